// File: doc/BRIEF.md
# Reorder Buffer Walk Controller

After a pipeline redirect, the reorder buffer has to revisit every speculative entry between a known recovery point and the redirecting instruction. It does this so that downstream rename-state buffers can undo their allocations. This controller sequences that recovery for a circular buffer of parameterized depth, 160 entries by default.

A redirect moves the controller into the walk state. At the same time it loads a start pointer, taken either from one of several saved snapshot start indices or from the current dequeue pointer. It also records the index of the last entry to walk. In walk, the pointer steps forward one bank line of eight entries per cycle until it passes the end index. Each cycle the controller produces an eight-bit mask that marks which entries of the current line must be walked. Commits are held off from the redirect cycle until the controller is back in idle. It returns to idle only once its own walk and both downstream walks have finished.

Every pointer is a wrap flag above a value field. Age is decided by comparing the two: when the flags are equal, the smaller value is older; when they differ, the larger value is older. All pointer ports are 9 bits wide by default: bit 8 is the flag and bits 7..0 are the value.

Top module: `rob_walk_ctrl`

## Requirements
- R1: After reset the controller is idle: `in_walk`=0, `commit_block`=0, `walk_ptr`=0 and `walk_vec`=0.
- R2: `in_walk` is 1 in every cycle whose previous cycle had `redir_valid`=1, so a walk always lasts at least two cycles.
- R3: The controller returns to idle only after a cycle in which `walk_finished`, `rab_walk_done` and `vtb_walk_done` were all 1 and no redirect was pending.
- R4: On a redirect, the walk start is snapshot `snap_sel` (slot k is bits k*9+8..k*9 of `snap_starts`) if `snap_use`=1, and `deq_ptr` otherwise. The `walk_ptr` shown in the first walk cycle is that start with value bits 2..0 cleared.
- R5: In walk, with no redirect and `walk_finished`=0, `walk_ptr` advances by 8 per cycle. When it reaches value 160 it wraps to value 0 and the flag inverts.
- R6: In idle, with no redirect, `walk_ptr` holds regardless of changes to `deq_ptr`.
- R7: The walk end index is `redir_idx`-1 when `redir_flush_self`=1 (value 0 wraps to 159 with the flag inverted), and `redir_idx` otherwise.
- R8: `walk_finished` is 1 when the unaligned walk pointer is younger than the walk end index. This comparison uses the flag rule above.
- R9: `walk_vec[i]` marks line entry `walk_ptr`+i. It is 1 only in walk and only when the entry is not younger than the walk end index. In the first walk cycle, it is also 0 for every i below the start's value bits 2..0.
- R10: `commit_block` is 1 in any cycle with `redir_valid`=1 and in every walk cycle, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| redir_valid | input | 1 | Redirect request this cycle |
| redir_idx | input | 9 | Index of the redirecting instruction (flag, value) |
| redir_flush_self | input | 1 | Redirecting instruction is itself discarded |
| snap_use | input | 1 | Start the walk from a saved snapshot |
| snap_sel | input | 2 | Snapshot slot to use |
| snap_starts | input | 36 | Start indices of the saved snapshots, slot 0 in the low bits |
| deq_ptr | input | 9 | Current dequeue pointer |
| rab_walk_done | input | 1 | Rename buffer reports its walk finished |
| vtb_walk_done | input | 1 | Vector-type buffer reports its walk finished |
| in_walk | output | 1 | Controller is in the walk state |
| commit_block | output | 1 | Commits are inhibited this cycle |
| walk_ptr | output | 9 | Line-aligned walk pointer |
| walk_finished | output | 1 | Controller's own walk has passed the end index |
| walk_vec | output | 8 | Entries of the current line to walk |

## Verification
The bench uses the default parameters: 160 entries, eight-entry lines and four snapshot slots. With this depth the last line starts at value 152, so a walk crosses the wrap boundary within two steps. The bench also places a self-flushing redirect at value 0, which forces the end index to wrap backward. Together these exercise both flag-inverting paths and the flag-aware age comparison. Four slots leave room for a snapshot whose wrap flag is already set, alongside start points that are aligned and unaligned.

// File: rtl/rob_walk_ctrl.sv
module rob_walk_ctrl #(
  parameter int ENTRIES = 160,
  parameter int LINE = 8,
  parameter int SNAPS = 4,
  localparam int VW = $clog2(ENTRIES),
  localparam int PW = VW + 1,
  localparam int SW = (SNAPS > 1) ? $clog2(SNAPS) : 1,
  localparam int OW = $clog2(LINE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               redir_valid,
  input  logic [PW-1:0]      redir_idx,
  input  logic               redir_flush_self,
  input  logic               snap_use,
  input  logic [SW-1:0]      snap_sel,
  input  logic [SNAPS*PW-1:0] snap_starts,
  input  logic [PW-1:0]      deq_ptr,
  input  logic               rab_walk_done,
  input  logic               vtb_walk_done,
  output logic               in_walk,
  output logic               commit_block,
  output logic [PW-1:0]      walk_ptr,
  output logic               walk_finished,
  output logic [LINE-1:0]    walk_vec
);

  localparam logic [VW:0]   STEP  = (VW+1)'(LINE);
  localparam logic [VW:0]   LIMIT = (VW+1)'(ENTRIES);
  localparam logic [VW-1:0] TOP   = VW'(ENTRIES - 1);

  function automatic logic older(input logic [PW-1:0] a, input logic [PW-1:0] b);
    if (a[VW] == b[VW]) return a[VW-1:0] < b[VW-1:0];
    return a[VW-1:0] > b[VW-1:0];
  endfunction

  function automatic logic [PW-1:0] step_line(input logic [PW-1:0] p);
    logic [VW:0] s;
    s = {1'b0, p[VW-1:0]} + STEP;
    if (s >= LIMIT) return {~p[VW], VW'(s - LIMIT)};
    return {p[VW], s[VW-1:0]};
  endfunction

  logic          walk_q, redir_d, first_q;
  logic [PW-1:0] wtrue_q, last_q, start, last_nxt;
  logic          walk_nxt;

  assign start    = snap_use ? snap_starts[snap_sel*PW +: PW] : deq_ptr;
  assign last_nxt = !redir_flush_self ? redir_idx :
                    (redir_idx[VW-1:0] == '0) ? {~redir_idx[VW], TOP} :
                    {redir_idx[VW], redir_idx[VW-1:0] - VW'(1)};

  assign walk_finished = older(last_q, wtrue_q);
  assign walk_nxt = (redir_valid || redir_d) ? 1'b1 :
                    (walk_q && walk_finished && rab_walk_done && vtb_walk_done) ? 1'b0 :
                    walk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_q  <= 1'b0;
      redir_d <= 1'b0;
      first_q <= 1'b0;
      wtrue_q <= '0;
      last_q  <= '0;
    end else begin
      walk_q  <= walk_nxt;
      redir_d <= redir_valid;
      if (redir_valid) begin
        wtrue_q <= start;
        last_q  <= last_nxt;
        first_q <= 1'b1;
      end else if (walk_q) begin
        first_q <= 1'b0;
        if (!walk_finished) wtrue_q <= step_line(wtrue_q);
      end
    end
  end

  assign in_walk      = walk_q;
  assign commit_block = redir_valid || walk_q;
  assign walk_ptr     = {wtrue_q[VW], wtrue_q[VW-1:OW], OW'(0)};

  for (genvar i = 0; i < LINE; i++) begin : g_vec
    logic [PW-1:0] ent;
    assign ent = {walk_ptr[VW], walk_ptr[VW-1:0] | VW'(i)};
    assign walk_vec[i] = walk_q && !older(last_q, ent) &&
                         !(first_q && (OW'(i) < wtrue_q[OW-1:0]));
  end

  AST_REDIR_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> in_walk); // R2
  AST_TWO_CYCLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !$past(redir_valid)) |=> ##1 in_walk); // R2
  AST_EXIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_walk && !(walk_finished && rab_walk_done && vtb_walk_done)) |=> in_walk); // R3
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_walk && !redir_valid && !walk_finished) |=> (walk_ptr != $past(walk_ptr))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_walk && !redir_valid) |=> $stable(walk_ptr)); // R6
  AST_IDLE_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !in_walk |-> (walk_vec == '0)); // R9
  AST_WALK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(redir_valid) |-> commit_block); // R10

endmodule

// File: tb/rob_walk_ctrl_tb.sv
module rob_walk_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic redir_valid = 1'b0;
  logic [8:0] redir_idx = '0;
  logic redir_flush_self = 1'b0;
  logic snap_use = 1'b0;
  logic [1:0] snap_sel = '0;
  logic [35:0] snap_starts;
  logic [8:0] deq_ptr = '0;
  logic rab_walk_done = 1'b1;
  logic vtb_walk_done = 1'b1;
  logic in_walk, commit_block, walk_finished;
  logic [8:0] walk_ptr;
  logic [7:0] walk_vec;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign snap_starts = {9'd152, 9'h108, 9'd40, 9'd16};

  rob_walk_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_idx(redir_idx),
    .redir_flush_self(redir_flush_self), .snap_use(snap_use), .snap_sel(snap_sel),
    .snap_starts(snap_starts), .deq_ptr(deq_ptr), .rab_walk_done(rab_walk_done),
    .vtb_walk_done(vtb_walk_done), .in_walk(in_walk), .commit_block(commit_block),
    .walk_ptr(walk_ptr), .walk_finished(walk_finished), .walk_vec(walk_vec)
  );

  // use, sel, deq, redir idx, flush, first aligned ptr, first vec, walk cycles, steps
  localparam logic [46:0] VEC [6] = '{
    {1'b0, 2'd0, 9'd13,  9'd30,   1'b0, 9'd8,    8'hE0, 4'd4, 4'd3},
    {1'b1, 2'd1, 9'd0,   9'd42,   1'b1, 9'd40,   8'h03, 4'd2, 4'd1},
    {1'b1, 2'd3, 9'd0,   9'h103,  1'b0, 9'd152,  8'hFF, 4'd3, 4'd2},
    {1'b0, 2'd0, 9'd144, 9'h100,  1'b1, 9'd144,  8'hFF, 4'd3, 4'd2},
    {1'b0, 2'd0, 9'd16,  9'd16,   1'b1, 9'd16,   8'h00, 4'd2, 4'd0},
    {1'b1, 2'd2, 9'd0,   9'h10A,  1'b0, 9'h108,  8'h07, 4'd2, 4'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] add8(input logic [8:0] p);
    if (p[7:0] + 9'd8 >= 9'd160) return {~p[8], 8'(p[7:0] + 9'd8 - 9'd160)};
    return {p[8], 8'(p[7:0] + 8'd8)};
  endfunction

  task automatic next_cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic redirect(input logic use_s, input logic [1:0] sel, input logic [8:0] dq,
                          input logic [8:0] idx, input logic fl);
    next_cycle();
    snap_use = use_s; snap_sel = sel; deq_ptr = dq;
    redir_idx = idx; redir_flush_self = fl; redir_valid = 1'b1;
    settle();
    check("R10 block on redirect", commit_block, 1);
    next_cycle();
    redir_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    settle();
    check("R1 walk", in_walk, 0);
    check("R1 block", commit_block, 0);
    check("R1 ptr", walk_ptr, 0);
    check("R1 vec", walk_vec, 0);
    rst_n = 1'b1;

    foreach (VEC[n]) begin
      logic [8:0] exp_ptr;
      int cyc;
      redirect(VEC[n][46], VEC[n][45:44], VEC[n][43:35], VEC[n][34:26], VEC[n][25]);
      settle();
      check("R2 walk after redirect", in_walk, 1);
      check("R4 first ptr", walk_ptr, VEC[n][24:16]);
      check("R9 first vec", walk_vec, VEC[n][15:8]);
      exp_ptr = VEC[n][24:16];
      cyc = 0;
      while (in_walk && cyc < 40) begin
        check("R5 walk ptr", walk_ptr, exp_ptr);
        check("R10 block in walk", commit_block, 1);
        if (cyc < int'(VEC[n][3:0])) exp_ptr = add8(exp_ptr);
        cyc++;
        next_cycle();
        settle();
      end
      check("R8 walk length", cyc, VEC[n][7:4]);
      check("R10 idle no block", commit_block, 0);
    end

    // R3: downstream walk-end gating
    redirect(1'b0, 2'd0, 9'd24, 9'd25, 1'b0);
    rab_walk_done = 1'b0; vtb_walk_done = 1'b0;
    repeat (5) next_cycle();
    settle();
    check("R3 held both busy", in_walk, 1);
    check("R8 own walk done", walk_finished, 1);
    rab_walk_done = 1'b1;
    repeat (2) next_cycle();
    settle();
    check("R3 held vtb busy", in_walk, 1);
    vtb_walk_done = 1'b1;
    next_cycle();
    settle();
    check("R3 walk ends", in_walk, 0);

    // R6: idle hold
    begin
      logic [8:0] held;
      held = walk_ptr;
      deq_ptr = 9'd77;
      repeat (3) next_cycle();
      settle();
      check("R6 ptr held", walk_ptr, held);
      check("R9 idle vec", walk_vec, 0);
    end

    // R7: flush-self at value 0 wraps end back; start equal to redir idx
    redirect(1'b0, 2'd0, 9'h100, 9'h100, 1'b1);
    settle();
    check("R7 wrapped end finished", walk_finished, 1);
    check("R7 vec empty", walk_vec, 0);
    redirect(1'b0, 2'd0, 9'h100, 9'h100, 1'b0);
    settle();
    check("R7 end at idx not finished", walk_finished, 0);
    check("R9 single entry", walk_vec, 8'h01);
    repeat (3) next_cycle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule